// File: doc/BRIEF.md
# Repeated String Move/Scan Engine

A sequential engine that carries out byte and word string operations over a byte-wide synchronous memory. Five operations are supported: move, store, load, scan and compare. A repeat option runs the chosen operation once per count. When a one-cycle `start` is seen, the engine captures its operands: two segment bases, source and destination offsets, a count, and a 16-bit accumulator. It then walks memory one byte per access and ends with a one-cycle `done`. The updated offsets, count, accumulator and zero flag stay on the outputs until the next start.

Each word is moved as two byte accesses, low byte first. Offsets step up or down according to the direction input, by one for bytes or two for words. Addresses are formed as segment times sixteen plus offset. Scan and compare set only the zero flag. Load and store touch only the accumulator and a single pointer.

Top module: `strop_engine`

## Requirements
- R1: Move (op code 0) copies the element at src_seg:src_off to dst_seg:dst_off and steps both offsets.
- R2: With dir_down=0 an offset that steps grows by 1 (byte) or 2 (word); with dir_down=1 it shrinks by the same amount; offsets wrap modulo 2^16.
- R3: Store (op code 1) writes the accumulator low byte (or the whole word) to the destination and steps only dst_off.
- R4: Load (op code 2) reads the source element into the accumulator and steps only src_off; a byte load leaves the upper accumulator byte unchanged.
- R5: A word element takes two byte accesses: the low byte at the element offset, the high byte at offset+1.
- R6: Scan (op code 3) sets zero_flag to 1 exactly when the accumulator (only its low byte in byte mode) equals the destination element; it steps dst_off and leaves acc unchanged.
- R7: Compare (op code 4) sets zero_flag to 1 exactly when the source and destination elements are equal (low bytes only in byte mode); it steps both offsets.
- R8: With rep_en=1 the operation repeats once per unit of count_in, count falls by one per element, and the run ends with count equal to 0.
- R9: With rep_en=1 and count_in=0 no memory access occurs, done is high in the cycle after start, and the offsets are left as loaded.
- R10: With rep_en=0 exactly one element is processed and count stays at count_in.
- R11: mem_addr equals segment*16 + offset, truncated to 20 bits. The +1 for a word's high byte wraps within the 16-bit offset.
- R12: done is a one-cycle pulse ending each operation; busy is high from the cycle after start through done; no memory access happens while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request, sampled while idle |
| op_sel | input | 3 | 0 move, 1 store, 2 load, 3 scan, 4 compare |
| word_mode | input | 1 | 1 selects 16-bit elements |
| rep_en | input | 1 | Repeat once per count |
| dir_down | input | 1 | 1 makes the offsets decrease |
| src_seg_in | input | 16 | Source segment |
| dst_seg_in | input | 16 | Destination segment |
| src_off_in | input | 16 | Initial source offset |
| dst_off_in | input | 16 | Initial destination offset |
| count_in | input | 16 | Initial repeat count |
| acc_in | input | 16 | Initial accumulator |
| mem_addr | output | 20 | Byte address |
| mem_rd | output | 1 | Read strobe, data returns next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, one cycle after mem_rd |
| src_off | output | 16 | Current source offset |
| dst_off | output | 16 | Current destination offset |
| count | output | 16 | Current count |
| acc | output | 16 | Current accumulator |
| zero_flag | output | 1 | Equality result of the last scan or compare |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |

## Verification
A wrong byte-select or sequencer state shows up at once on mem_addr: a word's two accesses arrive swapped, doubled or wrapped across the segment, in the same cycle as the error. A stepping fault in an offset or the count becomes visible on src_off, dst_off or count at the next element boundary. Across a repeated run it also corrupts whole stretches of the copied block, so comparing the two 512-byte regions after each run exposes it. A faulty zero-flag mask or byte capture shows only when the last scan or compare ends, through zero_flag.

// File: rtl/strop_pkg.sv
package strop_pkg;

  typedef enum logic [2:0] {
    OP_MOVE  = 3'd0,
    OP_STORE = 3'd1,
    OP_LOAD  = 3'd2,
    OP_SCAN  = 3'd3,
    OP_CMP   = 3'd4
  } str_op_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RSRC = 3'd1,
    S_GSRC = 3'd2,
    S_RDST = 3'd3,
    S_GDST = 3'd4,
    S_WDST = 3'd5,
    S_STEP = 3'd6,
    S_DONE = 3'd7
  } str_state_e;

endpackage

// File: rtl/strop_addr.sv
module strop_addr #(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  input  logic              hi_byte,
  output logic [ADDR_W-1:0] phys
);
  localparam int SUM_W = SEG_W + SEG_SHIFT + 1;

  logic [OFF_W-1:0] off_eff;
  logic [SUM_W-1:0] sum;

  always_comb begin
    off_eff = off + OFF_W'(hi_byte);
    sum     = (SUM_W'(seg) << SEG_SHIFT) + SUM_W'(off_eff);
    phys    = sum[ADDR_W-1:0];
  end
endmodule

// File: rtl/strop_step.sv
module strop_step #(
  parameter int OFF_W = 16
) (
  input  logic [OFF_W-1:0] off,
  input  logic             wide,
  input  logic             down,
  output logic [OFF_W-1:0] nxt
);
  logic [OFF_W-1:0] delta;

  always_comb begin
    delta = wide ? OFF_W'(2) : OFF_W'(1);
    nxt   = down ? off - delta : off + delta;
  end
endmodule

// File: rtl/strop_engine.sv
module strop_engine
  import strop_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int CNT_W     = 16,
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [2:0]          op_sel,
  input  logic                word_mode,
  input  logic                rep_en,
  input  logic                dir_down,
  input  logic [SEG_W-1:0]    src_seg_in,
  input  logic [SEG_W-1:0]    dst_seg_in,
  input  logic [OFF_W-1:0]    src_off_in,
  input  logic [OFF_W-1:0]    dst_off_in,
  input  logic [CNT_W-1:0]    count_in,
  input  logic [2*DATA_W-1:0] acc_in,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_rd,
  output logic                mem_wr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [OFF_W-1:0]    src_off,
  output logic [OFF_W-1:0]    dst_off,
  output logic [CNT_W-1:0]    count,
  output logic [2*DATA_W-1:0] acc,
  output logic                zero_flag,
  output logic                busy,
  output logic                done
);
  localparam int EW = 2 * DATA_W;

  str_state_e          st_q, st_d;
  str_op_e             op_q;
  logic                wide_q, rep_q, down_q, hi_q, zf_q;
  logic [SEG_W-1:0]    sseg_q, dseg_q;
  logic [OFF_W-1:0]    src_q, dst_q, src_nx, dst_nx;
  logic [CNT_W-1:0]    cnt_q, cnt_dec;
  logic [EW-1:0]       acc_q, tmp_a_q, tmp_b_q;
  logic                last_byte, byte_end, finish, src_adv, dst_adv, use_src;
  str_state_e          resume_st;

  function automatic str_state_e entry_state(str_op_e o);
    case (o)
      OP_STORE: return S_WDST;
      OP_SCAN:  return S_RDST;
      default:  return S_RSRC;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] pick(logic [EW-1:0] v, logic h);
    return h ? v[EW-1:DATA_W] : v[DATA_W-1:0];
  endfunction

  function automatic logic [EW-1:0] elem(logic [EW-1:0] v, logic w);
    return w ? v : {{DATA_W{1'b0}}, v[DATA_W-1:0]};
  endfunction

  // Datapath helpers
  strop_step #(.OFF_W(OFF_W)) u_src_step (
    .off(src_q), .wide(wide_q), .down(down_q), .nxt(src_nx));
  strop_step #(.OFF_W(OFF_W)) u_dst_step (
    .off(dst_q), .wide(wide_q), .down(down_q), .nxt(dst_nx));

  assign use_src = (st_q == S_RSRC);

  strop_addr #(.SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .SEG_SHIFT(SEG_SHIFT)) u_addr (
    .seg    (use_src ? sseg_q : dseg_q),
    .off    (use_src ? src_q : dst_q),
    .hi_byte(hi_q),
    .phys   (mem_addr)
  );

  // Next-state logic
  always_comb begin
    last_byte = !wide_q || hi_q;
    byte_end  = (st_q == S_GSRC && op_q != OP_MOVE && op_q != OP_CMP) ||
                (st_q == S_GDST) || (st_q == S_WDST);
    cnt_dec   = cnt_q - CNT_W'(1);
    finish    = !rep_q || (cnt_dec == '0);
    src_adv   = (op_q == OP_MOVE) || (op_q == OP_LOAD) || (op_q == OP_CMP);
    dst_adv   = (op_q == OP_MOVE) || (op_q == OP_STORE) || (op_q == OP_SCAN) ||
                (op_q == OP_CMP);
    resume_st = last_byte ? S_STEP : entry_state(op_q);
    st_d      = st_q;
    case (st_q)
      S_IDLE: if (start)
                st_d = (rep_en && count_in == '0) ? S_DONE : entry_state(str_op_e'(op_sel));
      S_RSRC: st_d = S_GSRC;
      S_RDST: st_d = S_GDST;
      S_GSRC: st_d = (op_q == OP_MOVE) ? S_WDST :
                     (op_q == OP_CMP)  ? S_RDST : resume_st;
      S_GDST: st_d = resume_st;
      S_WDST: st_d = resume_st;
      S_STEP: st_d = finish ? S_DONE : entry_state(op_q);
      S_DONE: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      op_q    <= OP_MOVE;
      wide_q  <= 1'b0;
      rep_q   <= 1'b0;
      down_q  <= 1'b0;
      hi_q    <= 1'b0;
      zf_q    <= 1'b0;
      sseg_q  <= '0;
      dseg_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      acc_q   <= '0;
      tmp_a_q <= '0;
      tmp_b_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && start) begin
        op_q   <= str_op_e'(op_sel);
        wide_q <= word_mode;
        rep_q  <= rep_en;
        down_q <= dir_down;
        hi_q   <= 1'b0;
        sseg_q <= src_seg_in;
        dseg_q <= dst_seg_in;
        src_q  <= src_off_in;
        dst_q  <= dst_off_in;
        cnt_q  <= count_in;
        acc_q  <= acc_in;
      end
      if (byte_end) hi_q <= !last_byte;
      if (st_q == S_GSRC) begin
        if (hi_q) tmp_a_q[EW-1:DATA_W] <= mem_rdata;
        else      tmp_a_q[DATA_W-1:0]  <= mem_rdata;
        if (op_q == OP_LOAD) begin
          if (hi_q) acc_q[EW-1:DATA_W] <= mem_rdata;
          else      acc_q[DATA_W-1:0]  <= mem_rdata;
        end
      end
      if (st_q == S_GDST) begin
        if (hi_q) tmp_b_q[EW-1:DATA_W] <= mem_rdata;
        else      tmp_b_q[DATA_W-1:0]  <= mem_rdata;
      end
      if (st_q == S_STEP) begin
        if (src_adv) src_q <= src_nx;
        if (dst_adv) dst_q <= dst_nx;
        if (rep_q)   cnt_q <= cnt_dec;
        if (op_q == OP_SCAN) zf_q <= (elem(acc_q, wide_q) == elem(tmp_b_q, wide_q));
        if (op_q == OP_CMP)  zf_q <= (elem(tmp_a_q, wide_q) == elem(tmp_b_q, wide_q));
      end
    end
  end

  assign mem_rd    = (st_q == S_RSRC) || (st_q == S_RDST);
  assign mem_wr    = (st_q == S_WDST);
  assign mem_wdata = (op_q == OP_MOVE) ? pick(tmp_a_q, hi_q) : pick(acc_q, hi_q);
  assign src_off   = src_q;
  assign dst_off   = dst_q;
  assign count     = cnt_q;
  assign acc       = acc_q;
  assign zero_flag = zf_q;
  assign busy      = (st_q != S_IDLE);
  assign done      = (st_q == S_DONE);
endmodule

// File: rtl/strop_engine_chk.sv
module strop_engine_chk #(
  parameter int OFF_W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             rep_en,
  input logic [CNT_W-1:0] count_in,
  input logic             busy,
  input logic             done,
  input logic             mem_rd,
  input logic             mem_wr,
  input logic [OFF_W-1:0] src_off,
  input logic [OFF_W-1:0] dst_off,
  input logic [CNT_W-1:0] count
);
  // R9: empty repeat finishes at once without touching memory
  a_r9_empty_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && rep_en && count_in == '0) |=> (done && !mem_rd && !mem_wr));

  // R12: done lasts a single cycle
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R12: memory is quiet while idle
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !mem_wr));

  // R5: one access per cycle
  a_r5_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr}));

  // R8: inside an operation the count only ever drops by one
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(count)) |-> (count == $past(count) - CNT_W'(1)));

  // R2: inside an operation the source offset moves by 1 or 2 either way
  a_r2_src_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(src_off)) |->
      (src_off == $past(src_off) + OFF_W'(1) || src_off == $past(src_off) - OFF_W'(1) ||
       src_off == $past(src_off) + OFF_W'(2) || src_off == $past(src_off) - OFF_W'(2)));

  // R2: same for the destination offset
  a_r2_dst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(dst_off)) |->
      (dst_off == $past(dst_off) + OFF_W'(1) || dst_off == $past(dst_off) - OFF_W'(1) ||
       dst_off == $past(dst_off) + OFF_W'(2) || dst_off == $past(dst_off) - OFF_W'(2)));
endmodule

bind strop_engine strop_engine_chk #(.OFF_W(OFF_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rep_en(rep_en), .count_in(count_in),
  .busy(busy), .done(done), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .src_off(src_off), .dst_off(dst_off), .count(count)
);

// File: tb/strop_engine_test.sv
module strop_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_sel = '0;
  logic        word_mode = 1'b0, rep_en = 1'b0, dir_down = 1'b0;
  logic [15:0] src_seg_in = '0, dst_seg_in = '0, src_off_in = '0, dst_off_in = '0;
  logic [15:0] count_in = '0, acc_in = '0;
  logic [19:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] src_off, dst_off, count, acc;
  logic        zero_flag, busy, done;

  int checks = 0, errors = 0, accesses = 0, lat = 0;
  logic [7:0]  mem [8192];
  logic [19:0] rd_log0 = '0, rd_log1 = '0;
  logic [7:0]  rdata_q = '0;

  always #5 clk = ~clk;

  strop_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .word_mode(word_mode),
    .rep_en(rep_en), .dir_down(dir_down), .src_seg_in(src_seg_in), .dst_seg_in(dst_seg_in),
    .src_off_in(src_off_in), .dst_off_in(dst_off_in), .count_in(count_in), .acc_in(acc_in),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .src_off(src_off), .dst_off(dst_off), .count(count), .acc(acc),
    .zero_flag(zero_flag), .busy(busy), .done(done));

  // Byte memory model, one-cycle read latency, 8 KiB mirrored
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr[12:0]] <= mem_wdata;
    if (mem_rd) begin
      rdata_q <= mem[mem_addr[12:0]];
      rd_log1 <= rd_log0;
      rd_log0 <= mem_addr;
    end
    if (mem_rd || mem_wr) accesses <= accesses + 1;
  end
  assign mem_rdata = rdata_q;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic init_mem();
    for (int i = 0; i < 8192; i++) mem[i] = pat(i);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic w, input logic rp, input logic dn,
                        input logic [15:0] ss, input logic [15:0] ds, input logic [15:0] si,
                        input logic [15:0] di, input logic [15:0] cx, input logic [15:0] ax);
    @(negedge clk);
    op_sel = op; word_mode = w; rep_en = rp; dir_down = dn;
    src_seg_in = ss; dst_seg_in = ds; src_off_in = si; dst_off_in = di;
    count_in = cx; acc_in = ax; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done) begin
      @(negedge clk);
      lat++;
    end
    @(negedge clk);
    check(!done && !busy, "R12 done pulse", {30'd0, done, busy}, 32'd0);
  endtask

  // {op3, w, rep, down, si, di, cx, exp_si, exp_di, exp_cx}
  localparam logic [101:0] TBL [12] = '{
    {3'd1, 1'b0, 1'b0, 1'b0, 16'h0010, 16'h0020, 16'd5, 16'h0010, 16'h0021, 16'd5},
    {3'd1, 1'b1, 1'b0, 1'b1, 16'h0010, 16'h0020, 16'd5, 16'h0010, 16'h001E, 16'd5},
    {3'd2, 1'b0, 1'b0, 1'b0, 16'h0010, 16'h0020, 16'd5, 16'h0011, 16'h0020, 16'd5},
    {3'd2, 1'b1, 1'b0, 1'b1, 16'h0010, 16'h0020, 16'd5, 16'h000E, 16'h0020, 16'd5},
    {3'd0, 1'b1, 1'b1, 1'b0, 16'h0010, 16'h0020, 16'd3, 16'h0016, 16'h0026, 16'd0},
    {3'd0, 1'b0, 1'b1, 1'b1, 16'h0010, 16'h0020, 16'd4, 16'h000C, 16'h001C, 16'd0},
    {3'd3, 1'b0, 1'b1, 1'b0, 16'h0010, 16'h0020, 16'd2, 16'h0010, 16'h0022, 16'd0},
    {3'd4, 1'b1, 1'b0, 1'b1, 16'h0010, 16'h0020, 16'd5, 16'h000E, 16'h001E, 16'd5},
    {3'd0, 1'b0, 1'b1, 1'b0, 16'h0010, 16'h0020, 16'd0, 16'h0010, 16'h0020, 16'd0},
    {3'd4, 1'b0, 1'b1, 1'b0, 16'h0010, 16'h0020, 16'd3, 16'h0013, 16'h0023, 16'd0},
    {3'd2, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h0020, 16'd5, 16'h0001, 16'h0020, 16'd5},
    {3'd1, 1'b1, 1'b1, 1'b1, 16'h0010, 16'h0000, 16'd2, 16'h0010, 16'hFFFC, 16'd0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R12 actual %0d expected %0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int acc0;
    int bad;
    init_mem();
    repeat (3) @(negedge clk);
    check(!busy && !done && !mem_rd && !mem_wr && !zero_flag && count == 0 && acc == 0,
          "R12 reset state", {busy, done, mem_rd, mem_wr, zero_flag, count, acc[10:0]}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R2 R3 R4 R8 R10 pointer and count results
    for (int k = 0; k < 12; k++) begin
      logic [101:0] v;
      v = TBL[k];
      init_mem();
      run_op(v[101:99], v[98], v[97], v[96], 16'h0100, 16'h0080,
             v[95:80], v[79:64], v[63:48], 16'h1234);
      check(src_off == v[47:32], "R2 R3 R4 src_off", {16'd0, src_off}, {16'd0, v[47:32]});
      check(dst_off == v[31:16], "R2 R3 R6 dst_off", {16'd0, dst_off}, {16'd0, v[31:16]});
      check(count == v[15:0], "R8 R10 count", {16'd0, count}, {16'd0, v[15:0]});
    end

    // R3 R5: store word, low byte first
    init_mem();
    run_op(3'd1, 1'b1, 1'b0, 1'b0, 16'h0100, 16'h0080, 16'h0000, 16'h0040, 16'd1, 16'hA55A);
    check(mem[13'h840] == 8'h5A, "R3 R5 store low", {24'd0, mem[13'h840]}, 32'h5A);
    check(mem[13'h841] == 8'hA5, "R3 R5 store high", {24'd0, mem[13'h841]}, 32'hA5);

    // R4: byte load keeps upper byte, word load fills both
    init_mem();
    run_op(3'd2, 1'b0, 1'b0, 1'b0, 16'h0100, 16'h0080, 16'h0030, 16'h0000, 16'd1, 16'h1234);
    check(acc == {8'h12, pat(32'h1030)}, "R4 byte load", {16'd0, acc}, {16'd0, 8'h12, pat(32'h1030)});
    run_op(3'd2, 1'b1, 1'b0, 1'b0, 16'h0100, 16'h0080, 16'h0030, 16'h0000, 16'd1, 16'h1234);
    check(acc == {pat(32'h1031), pat(32'h1030)}, "R4 R5 word load", {16'd0, acc},
          {16'd0, pat(32'h1031), pat(32'h1030)});

    // R6: scan
    run_op(3'd3, 1'b0, 1'b0, 1'b0, 16'h0100, 16'h0080, 16'h0000, 16'h0020, 16'd1,
           {8'hEE, pat(32'h820)});
    check(zero_flag == 1'b1, "R6 scan byte equal", {31'd0, zero_flag}, 32'd1);
    check(acc == {8'hEE, pat(32'h820)}, "R6 acc kept", {16'd0, acc}, {16'd0, 8'hEE, pat(32'h820)});
    run_op(3'd3, 1'b0, 1'b0, 1'b0, 16'h0100, 16'h0080, 16'h0000, 16'h0020, 16'd1,
           {8'h00, ~pat(32'h820)});
    check(zero_flag == 1'b0, "R6 scan byte differ", {31'd0, zero_flag}, 32'd0);
    run_op(3'd3, 1'b1, 1'b0, 1'b0, 16'h0100, 16'h0080, 16'h0000, 16'h0020, 16'd1,
           {pat(32'h821), pat(32'h820)});
    check(zero_flag == 1'b1, "R6 scan word equal", {31'd0, zero_flag}, 32'd1);

    // R7: compare
    mem[13'h1050] = 8'h77; mem[13'h850] = 8'h77;
    run_op(3'd4, 1'b0, 1'b0, 1'b0, 16'h0100, 16'h0080, 16'h0050, 16'h0050, 16'd1, 16'h0);
    check(zero_flag == 1'b1, "R7 compare equal", {31'd0, zero_flag}, 32'd1);
    mem[13'h850] = 8'h78;
    run_op(3'd4, 1'b0, 1'b0, 1'b0, 16'h0100, 16'h0080, 16'h0050, 16'h0050, 16'd1, 16'h0);
    check(zero_flag == 1'b0, "R7 compare differ", {31'd0, zero_flag}, 32'd0);
    mem[13'h1060] = 8'h01; mem[13'h860] = 8'h01; mem[13'h1061] = 8'h02; mem[13'h861] = 8'h03;
    run_op(3'd4, 1'b1, 1'b0, 1'b0, 16'h0100, 16'h0080, 16'h0060, 16'h0060, 16'd1, 16'h0);
    check(zero_flag == 1'b0, "R7 word high differs", {31'd0, zero_flag}, 32'd0);
    run_op(3'd4, 1'b0, 1'b0, 1'b0, 16'h0100, 16'h0080, 16'h0060, 16'h0060, 16'd1, 16'h0);
    check(zero_flag == 1'b1, "R7 byte mask", {31'd0, zero_flag}, 32'd1);

    // R9: empty repeat
    acc0 = accesses;
    run_op(3'd0, 1'b1, 1'b1, 1'b0, 16'h0100, 16'h0080, 16'h0044, 16'h0055, 16'd0, 16'h0);
    check(accesses == acc0, "R9 no access", accesses, acc0);
    check(lat == 1, "R9 done latency", lat, 32'd1);
    check(src_off == 16'h0044 && dst_off == 16'h0055, "R9 offsets kept",
          {src_off, dst_off}, 32'h00440055);

    // R11: address formation and wraps
    run_op(3'd2, 1'b1, 1'b0, 1'b0, 16'hF000, 16'h0080, 16'hFFFF, 16'h0000, 16'd1, 16'h0);
    check(rd_log1 == 20'hFFFFF, "R11 low byte addr", {12'd0, rd_log1}, 32'hFFFFF);
    check(rd_log0 == 20'hF0000, "R11 offset wrap", {12'd0, rd_log0}, 32'hF0000);
    run_op(3'd2, 1'b0, 1'b0, 1'b0, 16'hFFFF, 16'h0080, 16'h0010, 16'h0000, 16'd1, 16'h0);
    check(rd_log0 == 20'h00000, "R11 20-bit wrap", {12'd0, rd_log0}, 32'h0);

    // R1 R8: 0x200-byte block copy, upward by bytes
    init_mem();
    run_op(3'd0, 1'b0, 1'b1, 1'b0, 16'h0100, 16'h0080, 16'h0000, 16'h0000, 16'h0200, 16'h0);
    bad = 0;
    for (int i = 0; i < 512; i++) if (mem[13'h800 + i] != pat(32'h1000 + i)) bad++;
    check(bad == 0, "R1 R8 upward copy", bad, 0);
    check(src_off == 16'h0200 && dst_off == 16'h0200 && count == 0, "R8 upward final",
          {src_off, dst_off ^ count}, 32'h02000200);

    // R1 R2 R8: copy back, downward by words
    run_op(3'd0, 1'b1, 1'b1, 1'b1, 16'h0080, 16'h0140, 16'h01FE, 16'h01FE, 16'h0100, 16'h0);
    bad = 0;
    for (int i = 0; i < 512; i++) if (mem[13'h1400 + i] != pat(32'h1000 + i)) bad++;
    check(bad == 0, "R1 R8 downward copy", bad, 0);
    check(src_off == 16'hFFFE && dst_off == 16'hFFFE && count == 0, "R2 R8 downward final",
          {src_off, dst_off ^ count}, 32'hFFFEFFFE);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule